// File: doc/BRIEF.md
# Phase-Aligned Clock Divider Bank

This block runs on one fast reference clock, which stands in for a PLL output counter. From it the block produces several divided outputs. Each output has its own divide ratio of 1 to 256 and its own gate. Software writes all ratios on one bus and pulses a commit strobe. The block holds the new values in a shadow register and applies them to every output at once. The switch happens on the fast-clock cycle just before the slowest divided output would rise again. Because of this, all outputs restart together with a common rising edge, and no output gets a short pulse.

Each gate is sampled only on the last cycle of its output's period, so a gate change never cuts a high phase short. Software is expected to gate an output before it changes that output's ratio. The block also keeps the selected reference source as a registered code and raises a flag while the fabric-supplied source is in use. Nothing is switched in analog; the code is only stored and reported.

Top module: `clkdiv_bank`

## Requirements
- R1: While reset is low, every output is 0, `busy` is 0 and `src_cur` is 0. Every ratio resets to divide-by-1. After reset is released, every ungated output is high in the same first cycle.
- R2: Output i divides by N = field + 1, where the field is `div_in[8i+7:8i]`. Its period is N cycles. Its high phase is floor(N/2) cycles and starts at count 0. When N = 1 the output stays high.
- R3: A commit copies `div_in` into the shadow register. `busy` is high from the cycle after the commit until the new ratios take effect.
- R4: The new ratios take effect after the first fast-clock cycle that comes after the commit and is the last count of the slowest active output's period. In the next cycle, `busy` is low and every output restarts at count 0 together. For /16 with /4, the switch falls on count 15 of the /16 counter, which is also count 3 of the /4 counter.
- R5: A change on `div_in` without a commit has no effect on any output.
- R6: If a second commit arrives while one is pending, the later values are the ones applied.
- R7: When `gate_en[i]` is 0, output i is low. A new gate value is taken only on the last cycle of that output's period. A high phase that is under way always completes at full length.
- R8: A ratio changed while an output is gated takes effect normally. When the gate is lifted, the output gives only full-length pulses at the new ratio.
- R9: The source code in `src_sel` is registered into `src_cur` one cycle later: 0 is pin A, 1 is pin B, 2 is the fabric clock. Code 3 is ignored and the previous code is kept. `src_fabric` is high exactly when `src_cur` is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| div_in | input | NOUT*DW | Per-output ratio fields, N-1 each |
| commit | input | 1 | Captures div_in and requests an aligned update |
| gate_en | input | NOUT | Per-output enable, 1 = running |
| src_sel | input | 2 | Requested reference source code |
| clk_out | output | NOUT | Divided, gated outputs |
| busy | output | 1 | Update pending |
| src_cur | output | 2 | Registered source code |
| src_fabric | output | 1 | Fabric source is selected |

## Verification
Suppose a counter falls out of step after an update. The shared rising edge in the first cycle after `busy` falls would then be missing, and that shows at once. A wrong update instant shows up as a `busy` fall that is not on the first period boundary of the slowest old output after the commit. A gate sampled at the wrong time shows up as a shortened or extra high phase within one period of the gate change. The bench compares every output in every cycle against a model built from the requirements, so any of these faults is reported within one slow period.

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
  parameter int NOUT = 3,
  parameter int DW   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NOUT*DW-1:0]   div_in,
  input  logic                 commit,
  input  logic [NOUT-1:0]      gate_en,
  input  logic [1:0]           src_sel,
  output logic [NOUT-1:0]      clk_out,
  output logic                 busy,
  output logic [1:0]           src_cur,
  output logic                 src_fabric
);
  logic [NOUT-1:0][DW-1:0] shd, act, cnt;
  logic [DW-1:0] fcnt, amax;
  logic [NOUT-1:0] gate_q, raw;
  logic pend, upd;

  always_comb begin
    amax = '0;
    for (int i = 0; i < NOUT; i++)
      if (act[i] > amax) amax = act[i];
  end

  assign upd        = pend && (fcnt == amax);
  assign busy       = pend;
  assign src_fabric = (src_cur == 2'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd     <= '0;
      act     <= '0;
      pend    <= 1'b0;
      fcnt    <= '0;
      src_cur <= 2'd0;
    end else begin
      if (commit) shd <= div_in;
      if (upd) act <= shd;
      pend <= commit | (pend & ~upd);
      fcnt <= (fcnt == amax) ? '0 : fcnt + 1'b1;
      if (src_sel != 2'd3) src_cur <= src_sel;
    end
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_out
    logic [DW:0] hi;
    assign hi         = (act[g] == '0) ? (DW+1)'(1) : ({1'b0, act[g]} + (DW+1)'(1)) >> 1;
    assign raw[g]     = {1'b0, cnt[g]} < hi;
    assign clk_out[g] = raw[g] & gate_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt[g]    <= '0;
        gate_q[g] <= 1'b0;
      end else begin
        if (upd || cnt[g] == act[g]) cnt[g] <= '0;
        else                         cnt[g] <= cnt[g] + 1'b1;
        if (cnt[g] == act[g]) gate_q[g] <= gate_en[g];
      end
    end
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk #(
  parameter int NOUT = 3,
  parameter int DW   = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               commit,
  input logic               busy,
  input logic [1:0]         src_sel,
  input logic [1:0]         src_cur,
  input logic [NOUT*DW-1:0] act,
  input logic [NOUT*DW-1:0] cnt,
  input logic [NOUT-1:0]    gate_q
);
  a_r3_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);

  a_r4_restart_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (cnt == '0));

  a_r5_ratio_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(act));

  a_r9_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3) |=> $stable(src_cur));

  for (genvar g = 0; g < NOUT; g++) begin : g_chk
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g*DW +: DW] <= act[g*DW +: DW]);

    a_r7_gate_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gate_q[g]) |-> $past(cnt[g*DW +: DW] == act[g*DW +: DW]));
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.NOUT(NOUT), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .busy(busy),
  .src_sel(src_sel), .src_cur(src_cur), .act(act), .cnt(cnt), .gate_q(gate_q)
);

// File: tb/clkdiv_bank_test.sv
module clkdiv_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NOUT = 3;
  localparam int DW   = 8;
  localparam logic [23:0] VEC [4] = '{24'h00_03_0F, 24'h06_02_04, 24'hFF_09_01, 24'h01_07_07};

  logic clk = 0, rst_n = 0, commit = 0;
  logic [NOUT*DW-1:0] div_in = '0;
  logic [NOUT-1:0] gate_en = '1, clk_out, gm;
  logic [1:0] src_sel = 0, src_cur;
  logic busy, src_fabric;
  int errors = 0, checks = 0, kk = 0;
  int cur [NOUT];
  bit done = 0;

  clkdiv_bank #(.NOUT(NOUT), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .div_in(div_in), .commit(commit), .gate_en(gate_en),
    .src_sel(src_sel), .clk_out(clk_out), .busy(busy), .src_cur(src_cur), .src_fabric(src_fabric));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(bit ok, string req, int act_v, int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act_v, exp_v);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    kk++;
  endtask

  function automatic int nmax();
    int m = 1;
    for (int i = 0; i < NOUT; i++) if (cur[i] > m) m = cur[i];
    return m;
  endfunction

  function automatic int hiof(int n);
    return (n == 1) ? 1 : n / 2;
  endfunction

  task automatic walk(int w, int kg, logic [NOUT-1:0] gv, string req);
    int bad [NOUT];
    int first [NOUT];
    for (int i = 0; i < NOUT; i++) begin bad[i] = 0; first[i] = -1; end
    for (int c = 0; c < w; c++) begin
      for (int i = 0; i < NOUT; i++) begin
        logic e;
        if (kk % cur[i] == 0 && kk > 0) gm[i] = gate_en[i];
        e = gm[i] & ((kk % cur[i]) < hiof(cur[i]));
        if (clk_out[i] !== e) begin
          bad[i]++;
          if (first[i] < 0) first[i] = kk;
        end
      end
      if (c == kg) gate_en = gv;
      tick();
    end
    for (int i = 0; i < NOUT; i++)
      check(bad[i] == 0, req, first[i], -1);
  endtask

  task automatic do_commit(logic [23:0] v);
    int kc, nm, expk, lim;
    kc = kk; nm = nmax();
    expk = ((kc + 2 + nm - 1) / nm) * nm;
    div_in = v; commit = 1;
    tick();
    check(busy === 1'b1, "R3 busy after commit", busy, 1);
    commit = 0;
    lim = 0;
    while (busy === 1'b1 && lim < 700) begin tick(); lim++; end
    check(kk == expk, "R4 update instant", kk, expk);
    for (int i = 0; i < NOUT; i++) cur[i] = int'(v[i*8 +: 8]) + 1;
    gm = gate_en; kk = 0;
  endtask

  initial begin
    for (int i = 0; i < NOUT; i++) cur[i] = 1;
    repeat (3) tick();
    check(clk_out === '0, "R1 outputs in reset", int'(clk_out), 0);
    check(busy === 1'b0, "R1 busy in reset", busy, 0);
    check(src_cur === 2'd0 && src_fabric === 1'b0, "R1 source in reset", src_cur, 0);
    rst_n = 1;
    tick();
    check(clk_out === 3'b111, "R1 common first edge", int'(clk_out), 7);
    kk = 0; gm = gate_en;
    walk(6, -1, '1, "R2 divide-by-1");

    for (int v = 0; v < 4; v++) begin
      do_commit(VEC[v]);
      walk(2 * nmax() + 8, -1, '1, "R2 R4 period duty alignment");
    end

    div_in = 24'h3C_5A_11;
    walk(24, -1, '1, "R5 no effect without commit");
    check(busy === 1'b0, "R5 busy stays low", busy, 0);

    while (kk % 8 != 3) tick();
    begin
      int kc, expk;
      kc = kk; expk = ((kc + 2 + 7) / 8) * 8;
      div_in = 24'h02_05_0B; commit = 1; tick();
      div_in = 24'h00_02_05; tick();
      commit = 0;
      while (busy === 1'b1 && kk < 700) tick();
      check(kk == expk, "R6 update instant with double commit", kk, expk);
      cur[0] = 6; cur[1] = 3; cur[2] = 1; gm = gate_en; kk = 0;
      walk(30, -1, '1, "R6 later values applied");
    end

    do_commit(24'h00_03_07);
    walk(9, 1, 3'b110, "R7 gate off mid high");
    walk(40, 2, 3'b111, "R7 gate on mid period");

    walk(12, 0, 3'b101, "R8 gating before change");
    walk(12, -1, '1, "R8 gated steady");
    do_commit(24'h00_04_03);
    walk(30, 6, 3'b111, "R8 ungate after change");

    src_sel = 2'd2; tick();
    check(src_cur === 2'd2 && src_fabric === 1'b1, "R9 fabric select", src_cur, 2);
    src_sel = 2'd3; tick(); tick();
    check(src_cur === 2'd2, "R9 code 3 ignored", src_cur, 2);
    src_sel = 2'd1; tick();
    check(src_cur === 2'd1 && src_fabric === 1'b0, "R9 pin B select", src_cur, 1);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule